// File: doc/BRIEF.md
# Prescaled Free-Running Timer Base

This block is the time base of a microcontroller-style timer. A 16-bit up-counter is clocked from the bus clock through a prescaler that divides by 1, 4, 8 or 16. Software cannot load or stop the counter. It reads the count through a small byte-wide register port. A read of the high byte freezes the low byte, so software can assemble a consistent 16-bit value from two byte reads.

A second, independent chain produces a periodic tick. A 13-bit stage divides the bus clock by 8192. A post-divider then divides by 1, 2, 4 or 8. The counter wrap and the periodic tick each set a sticky flag. Software clears a flag by writing a one to its bit. Each flag has an enable bit, and the block raises one combined interrupt request.

The prescale choice is locked shortly after reset. It can be written only during the first 64 bus cycles. The periodic rate can be changed at any time.

Top module: `timer_base`

## Requirements
- R1: The count output is 16 bits wide and advances by exactly one per prescaled clock. Register writes to address 0 or 1 have no effect on it.
- R2: Control register (address 2) bits [1:0] select the counter divide: 0 divides by 1, 1 by 4, 2 by 8, and 3 by 16.
- R3: A write to the control bits [1:0] takes effect only on one of the first 64 rising clock edges after reset is released. Later writes leave both the readback of bits [1:0] and the count rate unchanged.
- R4: The overflow flag (flags register, address 3, bit 0) sets on the edge where the count goes from 0xFFFF to 0x0000.
- R5: Writing a one to a bit of the flags register clears that flag, and writing a zero leaves it unchanged. If a set event and a clearing write fall on the same edge, the flag ends up set.
- R6: The tick flag (flags register bit 1) sets on the bus-clock edge 8192×2^rate after reset release and then every 8192×2^rate cycles. Here rate is control bits [3:2].
- R7: The rate field may be rewritten at any time after reset, and the tick spacing follows the new value from the next 8192-cycle boundary.
- R8: The interrupt request equals (overflow flag AND control bit 4) OR (tick flag AND control bit 5).
- R9: A read strobe at address 0 returns the count's high byte and captures its low byte. A later read at address 1 returns the captured byte, not the live low byte.
- R10: While reset is held, the count is 0, the control register reads 0, and both flags and the interrupt request are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (captures low byte at address 0) |
| reg_addr | input | 2 | Register address: 0 count high, 1 captured low, 2 control, 3 flags |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from address |
| count_o | output | 16 | Live counter value |
| ovf_flag_o | output | 1 | Overflow flag |
| tick_flag_o | output | 1 | Periodic tick flag |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The counter, both flags and all register writes update on the rising edge after their cause. The bench therefore drives stimulus just after a falling edge and samples at the next falling edge. Read data is combinational from the address and is sampled one time step after the address changes. The captured low byte becomes visible on the next cycle. With prescale 1 the count equals the number of edges since reset release, so the bench uses the count as its timestamp and checks the window edges 63/64 and the event cycles 8192·2^rate and 65536 exactly. Rate checks compare count deltas over spans that are whole multiples of the divide, which makes them independent of the prescaler phase.

// File: rtl/timer_base_pkg.sv
package timer_base_pkg;

    typedef enum logic [1:0] {
        ADDR_CNT_HI = 2'd0,
        ADDR_CNT_LO = 2'd1,
        ADDR_CTRL   = 2'd2,
        ADDR_FLAGS  = 2'd3
    } reg_addr_e;

    // control field positions
    localparam int CTRL_PRE_LSB  = 0;
    localparam int CTRL_RATE_LSB = 2;
    localparam int CTRL_OVF_EN   = 4;
    localparam int CTRL_TICK_EN  = 5;

    // flag positions
    localparam int FLAG_OVF  = 0;
    localparam int FLAG_TICK = 1;

    localparam int PRE_W = 4;

    // low-bit mask of the free prescale counter for each divide choice
    function automatic logic [PRE_W-1:0] pre_mask(input logic [1:0] sel);
        logic [PRE_W-1:0] m;
        case (sel)
            2'd0:    m = 4'b0000;
            2'd1:    m = 4'b0011;
            2'd2:    m = 4'b0111;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tmr_main_count.sv
module tmr_main_count
    import timer_base_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       pre_sel,
    output logic [CNT_W-1:0] count,
    output logic             wrap_o
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t           st_d, st_q;
    logic             step;
    logic [PRE_W-1:0] mask;

    always_comb begin
        st_d   = st_q;
        mask   = pre_mask(pre_sel);
        step   = ((st_q.pre & mask) == mask);
        st_d.pre = st_q.pre + 1'b1;
        if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        wrap_o = step && (&st_q.cnt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(st_q.cnt)); // R1
    AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (st_q.cnt == '0)); // R4

endmodule

// File: rtl/tmr_periodic.sv
module tmr_periodic #(
    parameter int DIV_W  = 13,
    parameter int POST_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate_sel,
    output logic       tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [POST_W-1:0] post;
    } state_t;

    state_t            st_d, st_q;
    logic [POST_W-1:0] post_mask;
    logic              div_end;

    always_comb begin
        st_d      = st_q;
        post_mask = POST_W'((32'd1 << rate_sel) - 32'd1);
        div_end   = &st_q.div;
        st_d.div  = st_q.div + 1'b1;
        if (div_end) begin
            st_d.post = st_q.post + 1'b1;
        end
        tick_o = div_end && ((st_q.post & post_mask) == post_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R6

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import timer_base_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int WIN_CYC = 64,
    localparam int CNT_W  = 2 * DATA_W,
    localparam int WIN_W  = $clog2(WIN_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              wrap,
    input  logic              tick,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [1:0]        pre_sel,
    output logic [1:0]        rate_sel,
    output logic              ovf_flag,
    output logic              tick_flag,
    output logic              irq
);

    typedef struct packed {
        logic [WIN_W-1:0]  win;
        logic [1:0]        pre_sel;
        logic [1:0]        rate_sel;
        logic              ovf_en;
        logic              tick_en;
        logic              ovf_f;
        logic              tick_f;
        logic [DATA_W-1:0] snap;
    } state_t;

    state_t st_d, st_q;
    logic   win_open;
    logic   wr_ctrl, wr_flags;
    logic   clr_ovf, clr_tick;
    logic   unused_wbits;

    assign unused_wbits = ^reg_wdata[DATA_W-1:CTRL_TICK_EN+1];

    always_comb begin
        st_d     = st_q;
        win_open = (st_q.win < WIN_W'(WIN_CYC));
        wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
        wr_flags = reg_wr && (reg_addr == ADDR_FLAGS);
        clr_ovf  = wr_flags && reg_wdata[FLAG_OVF];
        clr_tick = wr_flags && reg_wdata[FLAG_TICK];

        if (win_open) begin
            st_d.win = st_q.win + 1'b1;
        end

        if (wr_ctrl) begin
            if (win_open) begin
                st_d.pre_sel = reg_wdata[CTRL_PRE_LSB +: 2];
            end
            st_d.rate_sel = reg_wdata[CTRL_RATE_LSB +: 2];
            st_d.ovf_en   = reg_wdata[CTRL_OVF_EN];
            st_d.tick_en  = reg_wdata[CTRL_TICK_EN];
        end

        // a set event outranks a clearing write on the same edge
        st_d.ovf_f  = wrap || (st_q.ovf_f  && !clr_ovf);
        st_d.tick_f = tick || (st_q.tick_f && !clr_tick);

        if (reg_rd && (reg_addr == ADDR_CNT_HI)) begin
            st_d.snap = count[DATA_W-1:0];
        end

        reg_rdata = '0;
        case (reg_addr)
            ADDR_CNT_HI: reg_rdata = count[CNT_W-1 -: DATA_W];
            ADDR_CNT_LO: reg_rdata = st_q.snap;
            ADDR_CTRL: begin
                reg_rdata[CTRL_PRE_LSB +: 2]  = st_q.pre_sel;
                reg_rdata[CTRL_RATE_LSB +: 2] = st_q.rate_sel;
                reg_rdata[CTRL_OVF_EN]        = st_q.ovf_en;
                reg_rdata[CTRL_TICK_EN]       = st_q.tick_en;
            end
            default: begin
                reg_rdata[FLAG_OVF]  = st_q.ovf_f;
                reg_rdata[FLAG_TICK] = st_q.tick_f;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pre_sel   = st_q.pre_sel;
    assign rate_sel  = st_q.rate_sel;
    assign ovf_flag  = st_q.ovf_f;
    assign tick_flag = st_q.tick_f;
    assign irq       = (st_q.ovf_f && st_q.ovf_en) || (st_q.tick_f && st_q.tick_en);

    AST_PRESCALE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |=> $stable(st_q.pre_sel)); // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> st_q.ovf_f); // R5
    AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flags && !reg_wdata[FLAG_OVF] && st_q.ovf_f) |=> st_q.ovf_f); // R5
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st_q.ovf_f || st_q.tick_f)); // R8

endmodule

// File: rtl/timer_base.sv
module timer_base #(
    parameter int DATA_W    = 8,
    parameter int WIN_CYC   = 64,
    parameter int TICK_DIVW = 13,
    parameter int TICK_POSTW = 3,
    localparam int CNT_W    = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [CNT_W-1:0]  count_o,
    output logic              ovf_flag_o,
    output logic              tick_flag_o,
    output logic              irq_o
);

    logic [1:0] pre_sel;
    logic [1:0] rate_sel;
    logic       wrap;
    logic       tick;

    tmr_main_count #(.CNT_W(CNT_W)) i_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .pre_sel (pre_sel),
        .count   (count_o),
        .wrap_o  (wrap)
    );

    tmr_periodic #(.DIV_W(TICK_DIVW), .POST_W(TICK_POSTW)) i_periodic (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_sel),
        .tick_o   (tick)
    );

    tmr_regs #(.DATA_W(DATA_W), .WIN_CYC(WIN_CYC)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .count     (count_o),
        .wrap      (wrap),
        .tick      (tick),
        .reg_rdata (reg_rdata),
        .pre_sel   (pre_sel),
        .rate_sel  (rate_sel),
        .ovf_flag  (ovf_flag_o),
        .tick_flag (tick_flag_o),
        .irq       (irq_o)
    );

endmodule

// File: tb/test_timer_base.sv
`timescale 1ns/1ps
module test_timer_base;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic [15:0] count_o;
    logic        ovf_flag_o, tick_flag_o, irq_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    timer_base i_timer_base (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .count_o(count_o), .ovf_flag_o(ovf_flag_o), .tick_flag_o(tick_flag_o),
        .irq_o(irq_o)
    );

    // vector: late(1) sel(2) span(8) expected delta(8)
    localparam logic [18:0] VEC [5] = '{
        {1'b0, 2'd0, 8'd20, 8'd20},
        {1'b0, 2'd1, 8'd40, 8'd10},
        {1'b0, 2'd2, 8'd40, 8'd5},
        {1'b0, 2'd3, 8'd48, 8'd3},
        {1'b1, 2'd3, 8'd32, 8'd32}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 2'd0; reg_wdata = 8'd0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'd0;
    endtask

    task automatic wait_count(input logic [15:0] c);
        while (count_o != c) @(negedge clk);
    endtask

    task automatic read_ctrl(output logic [7:0] v);
        reg_addr = 2'd2;
        #1 v = reg_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] c0;
        logic [7:0]  v;

        // vector table: prescale choices and late-write lock
        foreach (VEC[i]) begin
            do_reset();
            @(negedge clk);
            if (VEC[i][18]) wait_count(16'd70);
            wr_reg(2'd2, {6'd0, VEC[i][17:16]});
            read_ctrl(v);
            chk(v[1:0] == (VEC[i][18] ? 2'd0 : VEC[i][17:16]), "R2/R3 prescale readback",
                v[1:0], VEC[i][18] ? 0 : VEC[i][17:16]);
            c0 = count_o;
            repeat (int'(VEC[i][15:8])) @(negedge clk);
            chk(16'(count_o - c0) == 16'(VEC[i][7:0]), "R2 count delta",
                16'(count_o - c0), VEC[i][7:0]);
        end

        // window edge: last accepted edge
        do_reset();
        wait_count(16'd63);
        wr_reg(2'd2, 8'h01);
        read_ctrl(v);
        chk(v[1:0] == 2'd1, "R3 write at edge 64 accepted", v[1:0], 1);
        do_reset();
        wait_count(16'd64);
        wr_reg(2'd2, 8'h01);
        read_ctrl(v);
        chk(v[1:0] == 2'd0, "R3 write at edge 65 ignored", v[1:0], 0);

        // long run at prescale 1
        @(negedge clk);
        rst_n = 1'b0;
        reg_addr = 2'd2;
        #1;
        chk(count_o == 16'd0, "R10 count in reset", count_o, 0);
        chk(reg_rdata == 8'd0, "R10 ctrl in reset", reg_rdata, 0);
        chk({ovf_flag_o, tick_flag_o, irq_o} == 3'b000, "R10 flags in reset",
            {ovf_flag_o, tick_flag_o, irq_o}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        c0 = count_o;
        repeat (10) @(negedge clk);
        chk(16'(count_o - c0) == 16'd10, "R1 step per cycle", 16'(count_o - c0), 10);

        c0 = count_o;
        wr_reg(2'd0, 8'hAB);
        wr_reg(2'd1, 8'hCD);
        repeat (8) @(negedge clk);
        chk(16'(count_o - c0) == 16'd10, "R1 count writes ignored", 16'(count_o - c0), 10);

        wait_count(16'd70);
        wr_reg(2'd2, 8'h03);
        read_ctrl(v);
        chk(v[1:0] == 2'd0, "R3 late prescale ignored", v[1:0], 0);
        c0 = count_o;
        repeat (16) @(negedge clk);
        chk(16'(count_o - c0) == 16'd16, "R3 rate unchanged", 16'(count_o - c0), 16);

        wait_count(16'd100);
        wr_reg(2'd2, 8'h04);  // rate 1

        wait_count(16'h01FF);
        reg_rd = 1'b1; reg_addr = 2'd0;
        #1 chk(reg_rdata == 8'h01, "R9 high byte", reg_rdata, 8'h01);
        @(negedge clk);
        reg_rd = 1'b0; reg_addr = 2'd1;
        #1 chk(reg_rdata == 8'hFF, "R9 captured low byte", reg_rdata, 8'hFF);

        wait_count(16'd8192);
        chk(tick_flag_o == 1'b0, "R6 no tick at 8192 for rate 1", tick_flag_o, 0);
        wait_count(16'd16383);
        chk(tick_flag_o == 1'b0, "R6 no tick before 16384", tick_flag_o, 0);
        @(negedge clk);
        chk(tick_flag_o == 1'b1, "R6 tick at 16384", tick_flag_o, 1);
        chk(irq_o == 1'b0, "R8 no irq when disabled", irq_o, 0);

        wr_reg(2'd3, 8'h00);
        chk(tick_flag_o == 1'b1, "R5 zero write keeps flag", tick_flag_o, 1);
        wr_reg(2'd3, 8'h02);
        chk(tick_flag_o == 1'b0, "R5 one write clears flag", tick_flag_o, 0);

        wait_count(16'd32767);
        chk(tick_flag_o == 1'b0, "R6 flag clear before 32768", tick_flag_o, 0);
        wr_reg(2'd3, 8'h02);
        chk(tick_flag_o == 1'b1, "R5 set wins over clear", tick_flag_o, 1);
        wr_reg(2'd3, 8'h02);

        wait_count(16'd50000);
        wr_reg(2'd2, 8'h10);  // rate 0, overflow irq enabled
        wr_reg(2'd3, 8'h02);
        chk(tick_flag_o == 1'b0, "R7 flag cleared before rate change", tick_flag_o, 0);
        wait_count(16'd57343);
        chk(tick_flag_o == 1'b0, "R7 no tick before 57344", tick_flag_o, 0);
        @(negedge clk);
        chk(tick_flag_o == 1'b1, "R7 tick at 57344 after rate 0", tick_flag_o, 1);
        wr_reg(2'd3, 8'h02);

        wait_count(16'hFFFF);
        chk(ovf_flag_o == 1'b0, "R4 no overflow at 0xFFFF", ovf_flag_o, 0);
        chk(irq_o == 1'b0, "R8 irq low before overflow", irq_o, 0);
        @(negedge clk);
        chk(count_o == 16'd0, "R1 wrap to zero", count_o, 0);
        chk(ovf_flag_o == 1'b1, "R4 overflow flag set", ovf_flag_o, 1);
        chk(irq_o == 1'b1, "R8 irq from overflow", irq_o, 1);
        wr_reg(2'd3, 8'h01);
        chk(ovf_flag_o == 1'b0, "R5 overflow cleared", ovf_flag_o, 0);
        chk(irq_o == 1'b0, "R8 tick disabled gives no irq", irq_o, 0);
        wr_reg(2'd2, 8'h20);
        chk(irq_o == 1'b1, "R8 irq from tick when enabled", irq_o, 1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule